// File: doc/BRIEF.md
# Fast Ethernet transmit control register

A CPU-writable 16-bit control word for the transmit side of a 10/100 MAC, plus the small amount of logic its bits drive directly. Software programs the transmit enable, a general-purpose loopback pin, a forced-collision request and the engine options (padding, FCS suppression, carrier monitoring, full duplex and stop-on-SQE). An internal-loopback bit isolates the chip from the line. When it is set, the block drives the MII and serial transmit pins to idle levels and presents the carrier, collision and receive inputs to the core as 0.

The transmit engine reports four kinds of event: collision seen, SQE test error, fatal transmit error and frame complete. It also reports the start of each frame. The block uses these events to clear the enable and forced-collision bits on its own. In return it gives the engine a qualifier that says whether a new frame may begin. A frame already in flight when the enable drops is allowed to finish. After that, no new frame starts until the frame-complete pulse arrives, and the enable must also be set again.

Top module: `eth_tx_ctrl`

## Requirements
- R1: After reset every control bit is 0, reads return 0x0000, the loopback pin is low and the start qualifier is low.
- R2: A write loads the word. Only bits 0 (enable), 1 (loop pin), 2 (force collision), 7 (pad), 8 (no FCS), 10 (carrier monitor), 11 (full duplex), 12 (stop on SQE) and 13 (internal loopback) can be written. Every other bit reads 0, so writing 0xFFFF reads back 0x3D87. The option bits appear unchanged on the matching engine outputs.
- R3: The loopback pin output always equals bit 1.
- R4: While bit 13 is 1, the MII transmit data is 0, both transmit enables are 0 and the serial transmit data is 1. While bit 13 is 0, the engine's values pass through unchanged.
- R5: While bit 13 is 1, both carrier senses, both collision inputs, receive-valid and receive-error all reach the core as 0. While bit 13 is 0, they pass through.
- R6: A collision event while bit 2 is set clears bit 2 on the next edge. This clear wins over a CPU write in the same cycle.
- R7: A fatal transmit error clears bit 0. This clear wins over a CPU write in the same cycle.
- R8: An SQE error clears bit 0 when bit 12 is 1. When bit 12 is 0, an SQE error leaves bit 0 unchanged.
- R9: If bit 0 goes low while a frame is in flight, the start qualifier stays low until the frame-complete pulse. This holds even if bit 0 is set again before the pulse. Frame complete must be a single-cycle pulse.
- R10: When no halt is pending, the start qualifier equals bit 0. A start request that arrives while the qualifier is high marks a frame as in flight.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Register write strobe |
| wr_data_i | input | 16 | Register write data |
| rd_data_o | output | 16 | Register read data |
| coll_evt_i | input | 1 | Collision seen by transmit engine |
| sqe_err_i | input | 1 | SQE test error |
| fatal_err_i | input | 1 | Fatal transmit error |
| frame_start_i | input | 1 | Engine begins a frame |
| frame_done_i | input | 1 | Frame complete, single-cycle pulse |
| may_start_o | output | 1 | A new frame may begin |
| loop_pin_o | output | 1 | General-purpose loopback pin |
| force_coll_o | output | 1 | Forced-collision request to engine |
| pad_en_o | output | 1 | Pad short frames |
| no_fcs_o | output | 1 | Suppress FCS append |
| carrier_mon_o | output | 1 | Monitor own carrier |
| full_dup_o | output | 1 | Full duplex |
| eng_mii_txd_i | input | TXD_W | Engine MII transmit data |
| eng_mii_tx_en_i | input | 1 | Engine MII transmit enable |
| eng_ser_txd_i | input | 1 | Engine serial transmit data |
| eng_ser_tx_en_i | input | 1 | Engine serial transmit enable |
| mii_txd_o | output | TXD_W | MII transmit data pins |
| mii_tx_en_o | output | 1 | MII transmit enable pin |
| ser_txd_o | output | 1 | Serial transmit data pin |
| ser_tx_en_o | output | 1 | Serial transmit enable pin |
| pin_crs_i | input | 1 | Serial carrier sense pin |
| pin_mii_crs_i | input | 1 | MII carrier sense pin |
| pin_col_i | input | 1 | Serial collision pin |
| pin_mii_col_i | input | 1 | MII collision pin |
| pin_rx_dv_i | input | 1 | Receive data valid pin |
| pin_rx_er_i | input | 1 | Receive error pin |
| core_crs_o | output | 1 | Serial carrier sense to core |
| core_mii_crs_o | output | 1 | MII carrier sense to core |
| core_col_o | output | 1 | Serial collision to core |
| core_mii_col_o | output | 1 | MII collision to core |
| core_rx_dv_o | output | 1 | Receive data valid to core |
| core_rx_er_o | output | 1 | Receive error to core |

## Verification
The bench builds the block with its default nibble-wide MII data path, TXD_W = 4. At that width all sixteen transmit nibble values can be sent through the gate during random runs, so the forced-zero check under internal loopback is tested against every nibble value. The random stimulus sets the stop-on-SQE and force-collision bits often enough that events meet them both set and clear. It also lets writes land in the same cycle as hardware clears. Frame starts and completions follow the qualifier, which lets the enable drop mid-frame and come back before the completion pulse.

// File: rtl/eth_tx_ctrl_pkg.sv
package eth_tx_ctrl_pkg;
  localparam int unsigned REG_W      = 16;
  localparam int unsigned B_EN       = 0;
  localparam int unsigned B_LOOP_PIN = 1;
  localparam int unsigned B_FCOLL    = 2;
  localparam int unsigned B_PAD      = 7;
  localparam int unsigned B_NO_FCS   = 8;
  localparam int unsigned B_CMON     = 10;
  localparam int unsigned B_FDUP     = 11;
  localparam int unsigned B_SQE_STOP = 12;
  localparam int unsigned B_INT_LOOP = 13;

  localparam logic [REG_W-1:0] RW_MASK =
      REG_W'((1 << B_EN) | (1 << B_LOOP_PIN) | (1 << B_FCOLL) | (1 << B_PAD) |
             (1 << B_NO_FCS) | (1 << B_CMON) | (1 << B_FDUP) |
             (1 << B_SQE_STOP) | (1 << B_INT_LOOP));
endpackage

// File: rtl/eth_tx_ctrl_reg.sv
module eth_tx_ctrl_reg
  import eth_tx_ctrl_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_en_i,
  input  logic [REG_W-1:0] wr_data_i,
  input  logic             coll_evt_i,
  input  logic             sqe_err_i,
  input  logic             fatal_err_i,
  output logic [REG_W-1:0] ctrl_o
);
  logic [REG_W-1:0] ctrl_q, ctrl_d;
  logic en_clr, fcoll_clr;

  assign en_clr    = fatal_err_i | (sqe_err_i & ctrl_q[B_SQE_STOP]);
  assign fcoll_clr = coll_evt_i & ctrl_q[B_FCOLL];

  always_comb begin
    ctrl_d = wr_en_i ? (wr_data_i & RW_MASK) : ctrl_q;
    // hardware clears override a same-cycle write
    if (en_clr)    ctrl_d[B_EN]    = 1'b0;
    if (fcoll_clr) ctrl_d[B_FCOLL] = 1'b0;
  end

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) ctrl_q <= '0;
    else         ctrl_q <= ctrl_d;

  assign ctrl_o = ctrl_q;

  assert_fatal_clears_en_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fatal_err_i |=> !ctrl_q[B_EN]);
  assert_fcoll_selfclear_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (coll_evt_i && ctrl_q[B_FCOLL]) |=> !ctrl_q[B_FCOLL]);
  assert_sqe_ignored_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sqe_err_i && !ctrl_q[B_SQE_STOP] && !wr_en_i && !fatal_err_i)
      |=> (ctrl_q[B_EN] == $past(ctrl_q[B_EN])));
  assert_unused_bits_zero_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i |=> ((ctrl_q & ~RW_MASK) == '0));
endmodule

// File: rtl/eth_tx_ctrl_halt.sv
module eth_tx_ctrl_halt (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_q_i,
  input  logic en_d_i,
  input  logic frame_start_i,
  input  logic frame_done_i,
  output logic may_start_o
);
  logic busy_q, busy_d, pend_q, pend_d, start_ok;

  assign may_start_o = en_q_i & ~pend_q;
  assign start_ok    = frame_start_i & may_start_o;
  assign busy_d      = start_ok | (busy_q & ~frame_done_i);
  // pending once enable is seen low during a frame; held until completion
  assign pend_d      = busy_d & (pend_q | ~en_d_i);

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) begin
      busy_q <= 1'b0;
      pend_q <= 1'b0;
    end else begin
      busy_q <= busy_d;
      pend_q <= pend_d;
    end

  assert_done_pulse_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_done_i |=> !frame_done_i);
  assert_done_releases_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (frame_done_i && !frame_start_i) |=> !pend_q);
  assert_hold_until_done_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pend_q && !frame_done_i) |=> !may_start_o);
endmodule

// File: rtl/eth_tx_ctrl_gate.sv
module eth_tx_ctrl_gate #(
  parameter int unsigned TXD_W = 4
) (
  input  logic             iso_i,
  input  logic [TXD_W-1:0] eng_mii_txd_i,
  input  logic             eng_mii_tx_en_i,
  input  logic             eng_ser_txd_i,
  input  logic             eng_ser_tx_en_i,
  output logic [TXD_W-1:0] mii_txd_o,
  output logic             mii_tx_en_o,
  output logic             ser_txd_o,
  output logic             ser_tx_en_o,
  input  logic [5:0]       pin_in_i,
  output logic [5:0]       core_in_o
);
  assign mii_txd_o   = iso_i ? '0   : eng_mii_txd_i;
  assign mii_tx_en_o = iso_i ? 1'b0 : eng_mii_tx_en_i;
  assign ser_txd_o   = iso_i ? 1'b1 : eng_ser_txd_i;
  assign ser_tx_en_o = iso_i ? 1'b0 : eng_ser_tx_en_i;

  for (genvar g = 0; g < 6; g++) begin : g_mask
    assign core_in_o[g] = pin_in_i[g] & ~iso_i;
  end
endmodule

// File: rtl/eth_tx_ctrl.sv
module eth_tx_ctrl
  import eth_tx_ctrl_pkg::*;
#(
  parameter int unsigned TXD_W = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_en_i,
  input  logic [15:0]      wr_data_i,
  output logic [15:0]      rd_data_o,
  input  logic             coll_evt_i,
  input  logic             sqe_err_i,
  input  logic             fatal_err_i,
  input  logic             frame_start_i,
  input  logic             frame_done_i,
  output logic             may_start_o,
  output logic             loop_pin_o,
  output logic             force_coll_o,
  output logic             pad_en_o,
  output logic             no_fcs_o,
  output logic             carrier_mon_o,
  output logic             full_dup_o,
  input  logic [TXD_W-1:0] eng_mii_txd_i,
  input  logic             eng_mii_tx_en_i,
  input  logic             eng_ser_txd_i,
  input  logic             eng_ser_tx_en_i,
  output logic [TXD_W-1:0] mii_txd_o,
  output logic             mii_tx_en_o,
  output logic             ser_txd_o,
  output logic             ser_tx_en_o,
  input  logic             pin_crs_i,
  input  logic             pin_mii_crs_i,
  input  logic             pin_col_i,
  input  logic             pin_mii_col_i,
  input  logic             pin_rx_dv_i,
  input  logic             pin_rx_er_i,
  output logic             core_crs_o,
  output logic             core_mii_crs_o,
  output logic             core_col_o,
  output logic             core_mii_col_o,
  output logic             core_rx_dv_o,
  output logic             core_rx_er_o
);
  logic [REG_W-1:0] ctrl;
  logic [5:0] core_in;
  logic en_d;

  eth_tx_ctrl_reg u_reg (
    .clk_i, .rst_ni, .wr_en_i, .wr_data_i, .coll_evt_i, .sqe_err_i,
    .fatal_err_i, .ctrl_o(ctrl)
  );

  // next-state enable mirrors register update for halt tracking
  assign en_d = ~(fatal_err_i | (sqe_err_i & ctrl[B_SQE_STOP])) &
                (wr_en_i ? wr_data_i[B_EN] : ctrl[B_EN]);

  eth_tx_ctrl_halt u_halt (
    .clk_i, .rst_ni, .en_q_i(ctrl[B_EN]), .en_d_i(en_d),
    .frame_start_i, .frame_done_i, .may_start_o
  );

  eth_tx_ctrl_gate #(.TXD_W(TXD_W)) u_gate (
    .iso_i(ctrl[B_INT_LOOP]),
    .eng_mii_txd_i, .eng_mii_tx_en_i, .eng_ser_txd_i, .eng_ser_tx_en_i,
    .mii_txd_o, .mii_tx_en_o, .ser_txd_o, .ser_tx_en_o,
    .pin_in_i({pin_rx_er_i, pin_rx_dv_i, pin_mii_col_i, pin_col_i,
               pin_mii_crs_i, pin_crs_i}),
    .core_in_o(core_in)
  );

  assign {core_rx_er_o, core_rx_dv_o, core_mii_col_o, core_col_o,
          core_mii_crs_o, core_crs_o} = core_in;

  assign rd_data_o     = ctrl;
  assign loop_pin_o    = ctrl[B_LOOP_PIN];
  assign force_coll_o  = ctrl[B_FCOLL];
  assign pad_en_o      = ctrl[B_PAD];
  assign no_fcs_o      = ctrl[B_NO_FCS];
  assign carrier_mon_o = ctrl[B_CMON];
  assign full_dup_o    = ctrl[B_FDUP];

  assert_iso_idle_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_data_o[B_INT_LOOP] |-> (mii_txd_o == '0 && !mii_tx_en_o && !ser_tx_en_o && ser_txd_o));
  assert_iso_mask_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_data_o[B_INT_LOOP] |-> (core_in == 6'b0));
  assert_loop_pin_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i) |=> (loop_pin_o == $past(wr_data_i[B_LOOP_PIN])));
  assert_no_start_when_off_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_data_o[B_EN] |-> !may_start_o);
endmodule

// File: tb/eth_tx_ctrl_test.sv
module eth_tx_ctrl_test;
  localparam int TXD_W = 4;
  localparam logic [15:0] MASK = 16'h3D87;

  logic clk = 0, rst_ni = 0;
  always #2.5 clk = ~clk;

  logic wr_en = 0, coll = 0, sqe = 0, fatal = 0, fstart = 0, fdone = 0;
  logic [15:0] wdata = 0;
  logic [TXD_W-1:0] e_txd = 0;
  logic e_txen = 0, e_stxd = 0, e_stxen = 0;
  logic [5:0] pins = 0;
  logic [15:0] rd;
  logic may_start, loop_pin, fcoll_o, pad_o, nofcs_o, cmon_o, fdup_o;
  logic [TXD_W-1:0] txd;
  logic txen, stxd, stxen;
  logic [5:0] core;

  eth_tx_ctrl #(.TXD_W(TXD_W)) uut (
    .clk_i(clk), .rst_ni, .wr_en_i(wr_en), .wr_data_i(wdata), .rd_data_o(rd),
    .coll_evt_i(coll), .sqe_err_i(sqe), .fatal_err_i(fatal),
    .frame_start_i(fstart), .frame_done_i(fdone), .may_start_o(may_start),
    .loop_pin_o(loop_pin), .force_coll_o(fcoll_o), .pad_en_o(pad_o),
    .no_fcs_o(nofcs_o), .carrier_mon_o(cmon_o), .full_dup_o(fdup_o),
    .eng_mii_txd_i(e_txd), .eng_mii_tx_en_i(e_txen), .eng_ser_txd_i(e_stxd),
    .eng_ser_tx_en_i(e_stxen), .mii_txd_o(txd), .mii_tx_en_o(txen),
    .ser_txd_o(stxd), .ser_tx_en_o(stxen),
    .pin_crs_i(pins[0]), .pin_mii_crs_i(pins[1]), .pin_col_i(pins[2]),
    .pin_mii_col_i(pins[3]), .pin_rx_dv_i(pins[4]), .pin_rx_er_i(pins[5]),
    .core_crs_o(core[0]), .core_mii_crs_o(core[1]), .core_col_o(core[2]),
    .core_mii_col_o(core[3]), .core_rx_dv_o(core[4]), .core_rx_er_o(core[5])
  );

  int n_chk = 0, n_bad = 0;
  logic [15:0] m_reg = 0;
  logic m_busy = 0, m_pend = 0;

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] next_reg(logic [15:0] r, logic w, logic [15:0] d,
                                           logic f, logic s, logic c);
    logic [15:0] n = w ? (d & MASK) : r;
    if (f | (s & r[12])) n[0] = 1'b0;
    if (c & r[2])        n[2] = 1'b0;
    return n;
  endfunction

  function automatic logic model_may_start();
    return m_reg[0] & ~m_pend;
  endfunction

  task automatic check_now();
    logic iso = m_reg[13];
    chk("R2 read", rd, m_reg);
    chk("R2 opts", {pad_o, nofcs_o, cmon_o, fdup_o, fcoll_o},
        {m_reg[7], m_reg[8], m_reg[10], m_reg[11], m_reg[2]});
    chk("R3 loop pin", loop_pin, m_reg[1]);
    chk(m_pend ? "R9 hold" : "R10 qual", may_start, model_may_start());
    chk("R4 tx pins", {txd, txen, stxd, stxen},
        iso ? {{TXD_W{1'b0}}, 1'b0, 1'b1, 1'b0} : {e_txd, e_txen, e_stxd, e_stxen});
    chk("R5 rx mask", core, iso ? 6'b0 : pins);
  endtask

  // drive at negedge, check combinational outputs, advance one edge, update model
  task automatic step(logic w, logic [15:0] d, logic f, logic s, logic c,
                      logic st, logic dn);
    logic [15:0] nr;
    logic ok, bd;
    wr_en = w; wdata = d; fatal = f; sqe = s; coll = c; fstart = st; fdone = dn;
    e_txd = TXD_W'($urandom); e_txen = 1'($urandom); e_stxd = 1'($urandom);
    e_stxen = 1'($urandom); pins = 6'($urandom);
    #1 check_now();
    nr = next_reg(m_reg, w, d, f, s, c);
    ok = st & model_may_start();
    bd = ok | (m_busy & ~dn);
    m_pend = bd & (m_pend | ~nr[0]);
    m_busy = bd;
    m_reg = nr;
    @(negedge clk);
  endtask

  initial begin
    #100000;
    n_chk++; n_bad++;
    $display("FAIL watchdog act=hung exp=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'h1A2B3C4D));
    repeat (3) @(negedge clk);
    chk("R1 reset rd", rd, 0);
    chk("R1 reset pins", {loop_pin, may_start}, 0);
    rst_ni = 1;
    @(negedge clk);
    chk("R1 after release", rd, 0);

    step(1, 16'hFFFF, 0, 0, 0, 0, 0);
    chk("R2 mask 3D87", rd, 16'h3D87);
    step(1, 16'h0000, 0, 0, 0, 0, 0);
    // R6: collision clear beats same-cycle write
    step(1, 16'h0004, 0, 0, 0, 0, 0);
    step(1, 16'h0004, 0, 0, 1, 0, 0);
    chk("R6 hw wins", rd[2], 0);
    // R7: fatal beats write of enable
    step(1, 16'h0001, 0, 0, 0, 0, 0);
    step(1, 16'h0001, 1, 0, 0, 0, 0);
    chk("R7 hw wins", rd[0], 0);
    // R8: sqe without stop ignored, with stop clears
    step(1, 16'h0001, 0, 0, 0, 0, 0);
    step(0, 0, 0, 1, 0, 0, 0);
    chk("R8 ignored", rd[0], 1);
    step(1, 16'h1001, 0, 0, 0, 0, 0);
    step(0, 0, 0, 1, 0, 0, 0);
    chk("R8 stop", rd[0], 0);
    // R9: disable mid-frame, re-enable before done
    step(1, 16'h0001, 0, 0, 0, 0, 0);
    step(0, 0, 0, 0, 0, 1, 0);
    step(1, 16'h0000, 0, 0, 0, 0, 0);
    step(1, 16'h0001, 0, 0, 0, 0, 0);
    chk("R9 held after re-enable", may_start, 0);
    step(0, 0, 0, 0, 0, 0, 1);
    chk("R9 released", may_start, 1);
    // R4/R5: isolation on
    step(1, 16'h2000, 0, 0, 0, 0, 0);
    repeat (20) step(0, 0, 0, 0, 0, 0, 0);

    for (int i = 0; i < 4000; i++) begin
      logic w = ($urandom % 4) == 0;
      logic [15:0] d = 16'($urandom);
      logic st = 0, dn = 0;
      if (!m_busy) st = ($urandom % 3) == 0;
      else dn = ($urandom % 4) == 0;
      if ($urandom % 2) d[0] = 1'b1;
      step(w, d, ($urandom % 16) == 0, ($urandom % 8) == 0,
           ($urandom % 6) == 0, st, dn);
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule